// File: doc/BRIEF.md
# Indexed Colour Palette Access Port

This block gives a CPU byte-wide access to a colour palette store of 64 entries, each 16 bits wide. The store is split into two halves: background colours in entries 0 to 31 and object colours in entries 32 to 63. Each half has its own channel. A channel has an index register, which selects one byte of its 32 entries, and a data register, which reads or writes that byte.

Bit 0 of a channel's 6-bit byte index selects the low or high byte of a colour entry. The remaining index bits select the entry within the channel's half. When the index register's increment flag is set, each data write moves the index to the next byte. This lets software stream a whole palette with back-to-back data writes.

The data register is a latched copy of the addressed byte. It is reloaded in the same clock edge that changes the index, so a read straight after an index write or a data write returns the new byte. Reads are combinational from the register selected by the address and have no side effects.

Top module: `pal_port_top`

## Requirements
- R1: After reset, both index registers read 0x40 (index 0, increment off) and both data registers read 0x00. The whole store is cleared to zero.
- R2: Registers are selected by `addr_i`: 0 is the background index, 1 is background data, 2 is the object index and 3 is object data. Writing an index register stores bits 5:0 as the byte index and bit 7 as the increment flag. The register reads back as {flag, 1, index}, so bit 6 always reads as 1.
- R3: From the cycle after any index or data write, the data register of that channel returns the store byte at the channel's current index.
- R4: Byte index bit 0 selects the low byte (0) or the high byte (1) of the colour entry. Bits 5:1 select the entry.
- R5: A data write changes only the addressed byte of the 16-bit entry. The other byte keeps its value.
- R6: With the increment flag set, each data write advances the index by one, and index 63 wraps to 0.
- R7: With the increment flag clear, a data write leaves the index unchanged, and the written value reads back from the data register.
- R8: The background channel reaches entries 0 to 31 and the object channel reaches entries 32 to 63. A write through one channel is never visible through the other channel at the same index.
- R9: Reading any register, for any number of cycles, changes no index, flag or store byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the register selected by addr_i |
| addr_i | input | 2 | Register select: 0 bg index, 1 bg data, 2 obj index, 3 obj data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the register selected by addr_i |

## Verification
The hardest case to reach is the wrap from index 63 to 0 under auto-increment. It needs an index write with the flag set at the very top of the range, followed by data writes on both sides of the wrap. It has to be run on both channels, so that a wrap which leaked into the other half of the store would show up. The stimulus places this directly. It then writes low and high bytes of the same entry in succession to expose lane corruption, and finishes with a long run of random register writes. A behavioural byte-array model is compared against all four readable registers after every operation.

// File: rtl/pal_port_pkg.sv
package pal_port_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  // addr_i[1] picks the channel, addr_i[0] picks data (1) or index (0)
  typedef enum logic [1:0] {
    SEL_BG_IDX  = 2'd0,
    SEL_BG_DAT  = 2'd1,
    SEL_OBJ_IDX = 2'd2,
    SEL_OBJ_DAT = 2'd3
  } pal_sel_e;
endpackage

// File: rtl/pal_ram.sv
module pal_ram
  import pal_port_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned NRD   = 2,
  localparam int unsigned EW   = 2 * BYTE_W,
  localparam int unsigned AW   = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  byte_t             wbyte_i,
  input  logic [NRD*AW-1:0] raddr_i,
  output logic [NRD*BYTE_W-1:0] rbyte_o
);
  logic [EW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      if (waddr_i[0]) mem_q[waddr_i[AW-1:1]][EW-1:BYTE_W] <= wbyte_i;
      else            mem_q[waddr_i[AW-1:1]][BYTE_W-1:0]  <= wbyte_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [AW-1:0] ra;
    assign ra = raddr_i[g*AW +: AW];
    assign rbyte_o[g*BYTE_W +: BYTE_W] = ra[0] ? mem_q[ra[AW-1:1]][EW-1:BYTE_W]
                                               : mem_q[ra[AW-1:1]][BYTE_W-1:0];
  end

  AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !waddr_i[0]) |=> mem_q[$past(waddr_i[AW-1:1])][EW-1:BYTE_W]
                              == $past(mem_q[waddr_i[AW-1:1]][EW-1:BYTE_W])); // R5
  AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i[0]) |=> mem_q[$past(waddr_i[AW-1:1])][BYTE_W-1:0]
                             == $past(mem_q[waddr_i[AW-1:1]][BYTE_W-1:0])); // R5
endmodule

// File: rtl/pal_idx_port.sv
module pal_idx_port
  import pal_port_pkg::*;
#(
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned AW        = 7,
  parameter int unsigned BASE_BYTE = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic          dat_we_i,
  input  byte_t         wdata_i,
  input  byte_t         ram_byte_i,
  output logic [AW-1:0] lookup_addr_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_waddr_o,
  output byte_t         idx_rd_o,
  output byte_t         dat_rd_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             inc_q;
  byte_t            dat_q, dat_d;

  always_comb begin
    idx_d = idx_q;
    if (idx_we_i)              idx_d = wdata_i[IDX_W-1:0];
    else if (dat_we_i && inc_q) idx_d = IDX_W'(idx_q + 1'b1);
  end

  assign lookup_addr_o = AW'(BASE_BYTE) + AW'(idx_d);
  assign ram_waddr_o   = AW'(BASE_BYTE) + AW'(idx_q);
  assign ram_we_o      = dat_we_i;

  // a non-incrementing write stays on the byte just written; RAM is not yet updated
  assign dat_d = (dat_we_i && !inc_q) ? wdata_i : ram_byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      inc_q <= 1'b0;
      dat_q <= '0;
    end else begin
      idx_q <= idx_d;
      if (idx_we_i) inc_q <= wdata_i[BYTE_W-1];
      if (idx_we_i || dat_we_i) dat_q <= dat_d;
    end
  end

  assign idx_rd_o = {inc_q, 1'b1, idx_q};
  assign dat_rd_o = dat_q;

  AST_IDX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_we_i |=> idx_q == $past(wdata_i[IDX_W-1:0])); // R2
  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_we_i && inc_q && !idx_we_i) |=> idx_q == IDX_W'($past(idx_q) + 1'b1)); // R6
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_we_i && !(dat_we_i && inc_q)) |=> $stable(idx_q)); // R7
  AST_DAT_COHERENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_we_i && !dat_we_i) |-> dat_q == ram_byte_i); // R3
endmodule

// File: rtl/pal_port_top.sv
module pal_port_top
  import pal_port_pkg::*;
#(
  parameter int unsigned DEPTH          = 64,
  parameter int unsigned OBJ_BASE_ENTRY = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  localparam int unsigned NCH   = 2;
  localparam int unsigned IDX_W = 6;
  localparam int unsigned AW    = $clog2(DEPTH) + 1;

  logic [NCH*AW-1:0]     lookup;
  logic [NCH*BYTE_W-1:0] rbytes;
  logic [NCH-1:0]        ch_we;
  logic [AW-1:0]         ch_waddr [NCH];
  byte_t                 idx_rd [NCH];
  byte_t                 dat_rd [NCH];
  logic                  ram_we;
  logic [AW-1:0]         ram_waddr;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int unsigned BASE = (g == 0) ? 0 : 2 * OBJ_BASE_ENTRY;
    logic sel;
    assign sel = (addr_i[1] == 1'(g));
    pal_idx_port #(.IDX_W(IDX_W), .AW(AW), .BASE_BYTE(BASE)) u_port (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .idx_we_i     (wr_en_i && sel && !addr_i[0]),
      .dat_we_i     (wr_en_i && sel && addr_i[0]),
      .wdata_i      (wdata_i),
      .ram_byte_i   (rbytes[g*BYTE_W +: BYTE_W]),
      .lookup_addr_o(lookup[g*AW +: AW]),
      .ram_we_o     (ch_we[g]),
      .ram_waddr_o  (ch_waddr[g]),
      .idx_rd_o     (idx_rd[g]),
      .dat_rd_o     (dat_rd[g])
    );
  end

  always_comb begin
    ram_we    = |ch_we;
    ram_waddr = ch_waddr[0];
    for (int i = 0; i < NCH; i++) if (ch_we[i]) ram_waddr = ch_waddr[i];
  end

  pal_ram #(.DEPTH(DEPTH), .NRD(NCH)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ram_we),
    .waddr_i(ram_waddr),
    .wbyte_i(wdata_i),
    .raddr_i(lookup),
    .rbyte_o(rbytes)
  );

  assign rdata_o = addr_i[0] ? dat_rd[addr_i[1]] : idx_rd[addr_i[1]];

  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_we)); // R8
  AST_BG_IN_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_we[0] |-> ch_waddr[0] < AW'(2 * OBJ_BASE_ENTRY)); // R8
  AST_OBJ_IN_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_we[1] |-> ch_waddr[1] >= AW'(2 * OBJ_BASE_ENTRY)); // R8
endmodule

// File: tb/sim_pal_port_top.sv
module sim_pal_port_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] m_mem [128];
  int m_idx [2];
  bit m_inc [2];

  always #4 clk = ~clk;

  pal_port_top u0 (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
                   .wdata_i(wdata), .rdata_o(rdata));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1 v = rdata;
  endtask

  function automatic logic [7:0] exp_reg(input int a);
    int ch = a / 2;
    if (a % 2 == 0) return {m_inc[ch], 1'b1, 6'(m_idx[ch])};
    return m_mem[ch*64 + m_idx[ch]];
  endfunction

  task automatic compare_all(input string tag);
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check((a % 2 == 0) ? {tag, "/R2"} : {tag, "/R3"}, v, exp_reg(a));
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    int ch = a[1];
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    if (!a[0]) begin
      m_idx[ch] = d[5:0]; m_inc[ch] = d[7];
    end else begin
      m_mem[ch*64 + m_idx[ch]] = d;
      if (m_inc[ch]) m_idx[ch] = (m_idx[ch] + 1) % 64;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
    for (int c = 0; c < 2; c++) begin m_idx[c] = 0; m_inc[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 bg idx", v, 8'h40);
    rd(2'd1, v); check("R1 bg dat", v, 8'h00);
    rd(2'd2, v); check("R1 obj idx", v, 8'h40);
    rd(2'd3, v); check("R1 obj dat", v, 8'h00);

    // R2 bit 6 reads 1 whatever is written
    wr(2'd0, 8'h05); rd(2'd0, v); check("R2 idx no flag", v, 8'h45);
    wr(2'd0, 8'hC7); rd(2'd0, v); check("R2 idx flag", v, 8'hC7);

    // R7 no increment: index holds, written byte reads back
    wr(2'd0, 8'h04); wr(2'd1, 8'hA1);
    rd(2'd0, v); check("R7 idx held", v, 8'h44);
    rd(2'd1, v); check("R7 dat readback", v, 8'hA1);

    // R4/R5 lanes of entry 2: byte 4 low, byte 5 high
    wr(2'd0, 8'h05); wr(2'd1, 8'hB2);
    wr(2'd0, 8'h04); rd(2'd1, v); check("R5 low kept", v, 8'hA1);
    wr(2'd0, 8'h05); rd(2'd1, v); check("R4 high lane", v, 8'hB2);
    wr(2'd1, 8'hC3);
    wr(2'd0, 8'h04); rd(2'd1, v); check("R5 low kept again", v, 8'hA1);

    // R3 refresh on index write
    wr(2'd0, 8'h05); rd(2'd1, v); check("R3 refresh", v, 8'hC3);

    // R6 wrap on both channels
    for (int c = 0; c < 2; c++) begin
      wr(2'(2*c), 8'hBE);
      wr(2'(2*c+1), 8'h10 + 8'(c));
      rd(2'(2*c), v); check("R6 step", v, 8'hFF);
      wr(2'(2*c+1), 8'h20 + 8'(c));
      rd(2'(2*c), v); check("R6 wrap", v, 8'hC0);
      wr(2'(2*c+1), 8'h30 + 8'(c));
      rd(2'(2*c), v); check("R6 after wrap", v, 8'hC1);
      compare_all("R6");
    end

    // R8 separation: same index, different halves
    wr(2'd0, 8'h0A); wr(2'd1, 8'h5A);
    wr(2'd2, 8'h0A); wr(2'd3, 8'hA5);
    rd(2'd1, v); check("R8 bg intact", v, 8'h5A);
    rd(2'd3, v); check("R8 obj own", v, 8'hA5);

    // R9 reads only, held over many cycles
    for (int k = 0; k < 20; k++) begin
      rd(2'(k % 4), v);
    end
    compare_all("R9");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      wr(2'($urandom_range(0, 3)), 8'($urandom));
      compare_all("R3R4rand");
    end

    // full-store sweep through data ports, R4
    for (int c = 0; c < 2; c++) begin
      wr(2'(2*c), 8'h80);
      for (int b = 0; b < 64; b++) begin
        rd(2'(2*c+1), v);
        check("R4 sweep", v, m_mem[c*64 + m_idx[c]]);
        wr(2'(2*c+1), v);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule